// File: doc/BRIEF.md
# Issue Queue Resize Controller

This controller decides when an out-of-order issue queue should give up or take back one portion of its entries. Time is split into fixed quanta of clock cycles. During each quantum the block adds up the committed instructions that carry a "youngest portion" mark. That mark is set when the instruction is dispatched into the portion that was youngest at that moment, and it travels with the instruction until commit. Up to four commit lanes can present such instructions in one cycle.

On the last cycle of each quantum the total is compared with a threshold. A portion that delivers fewer marked commits than the threshold is not earning its wake-up power, so the block raises a one-cycle shrink pulse. Growth works differently: every fifth quantum the block asks for one more portion without looking at any statistics. If the extra portion turns out to be useless, a later shrink decision removes it again.

The queue logic reports how many portions are currently active. The controller uses that count only to avoid asking for a portion below the minimum or above the maximum. Each pulse is a request to change the queue size by exactly one portion.

Top module: `queue_resize_ctrl`

## Requirements
- R1: Decisions fall only on the boundary cycle of a quantum. A quantum is 1000 cycles long. Counting the first cycle after reset release as cycle 0, the boundary cycles are 999, 1999, 2999 and so on. On every other cycle both pulses stay low.
- R2: In each cycle the tally adds the number of lanes i where commit_vld[i] and commit_young[i] are both 1. All four lanes can count in the same cycle. A lane with the mark but no valid does not count, and neither does a valid lane without the mark. Commits on the boundary cycle itself belong to the quantum that is closing.
- R3: On a boundary, shrink_pulse goes high when the quantum's total is below 25. A total of exactly 25 or more gives no shrink.
- R4: The tally restarts from zero after every boundary. The decision in each quantum depends only on the commits inside that quantum.
- R5: grow_pulse is requested on every fifth boundary, at quantum indices 4, 9, 14 and so on, counted from 0 after reset. The commit totals play no part in this request.
- R6: No grow pulse is issued while active_portions is 16 or more.
- R7: No shrink pulse is issued while active_portions is 1 or less. Above that floor, any number of consecutive shrinks is allowed.
- R8: When a shrink pulse is issued on a grow boundary, the grow is dropped. When a low total is blocked by the floor of R7, the grow still goes out. The two pulses are never high together.
- R9: Each pulse lasts one cycle. It is combinational during the boundary cycle, so it reflects that cycle's commit lanes.
- R10: An active-low asynchronous reset clears the cycle count, the tally and the quantum index. Both pulses stay low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_vld | input | COMMIT_W (4) | One bit per commit lane: that lane commits this cycle |
| commit_young | input | COMMIT_W (4) | Youngest-portion mark carried by the instruction on each lane |
| active_portions | input | PORT_W (5) | Number of portions currently enabled in the queue |
| grow_pulse | output | 1 | One-cycle request to enable one more portion |
| shrink_pulse | output | 1 | One-cycle request to disable the youngest portion |

## Verification
The bench feeds complete quanta with marked commits packed four per cycle, spread one per cycle, or held back to the final cycles. Holding them back checks that commits on the boundary cycle are counted, and the totals 24, 25 and 26 place the shrink threshold exactly. Some quanta also drive lanes that are valid without the mark or marked without valid; the 24/25 outcome then shows whether these noise lanes leak into the tally. The portion count is set to 1, 2, 15 and 16 on chosen boundaries to tell the floor, the ceiling and the shrink-over-grow rule apart. A reset in the middle of a quantum, with commits already counted, shows whether the tally and the grow schedule really restart.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

  // Widest commit group the lane counter handles.
  localparam int MAX_LANES = 16;

  // Number of set bits in a lane mask (counted lanes this cycle).
  function automatic logic [4:0] count_lanes(input logic [MAX_LANES-1:0] mask);
    logic [4:0] n;
    n = '0;
    for (int i = 0; i < MAX_LANES; i++) begin
      n = n + {4'b0000, mask[i]};
    end
    return n;
  endfunction

  // The youngest portion under-performs when its total is below the threshold.
  function automatic logic rate_is_low(input int unsigned total,
                                       input int unsigned thresh);
    return total < thresh;
  endfunction

  // Wrapping increment of a modulo counter whose last value is 'last'.
  function automatic int unsigned wrap_next(input int unsigned value,
                                            input int unsigned last);
    return (value >= last) ? 0 : value + 1;
  endfunction

endpackage

// File: rtl/rsz_quantum_timer.sv
module rsz_quantum_timer #(
  parameter int QUANTUM_CYCLES = 1000,
  parameter int GROW_QUANTA    = 5,
  localparam int CYC_W = $clog2(QUANTUM_CYCLES + 1),
  localparam int QI_W  = $clog2(GROW_QUANTA + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic boundary,
  output logic grow_due
);
  import rsz_pkg::*;

  logic [CYC_W-1:0] cyc_q;
  logic [QI_W-1:0]  qidx_q;
  logic             last_quantum;

  assign boundary     = (cyc_q == CYC_W'(QUANTUM_CYCLES - 1));
  assign last_quantum = (qidx_q == QI_W'(GROW_QUANTA - 1));
  assign grow_due     = boundary && last_quantum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      qidx_q <= '0;
    end else begin
      cyc_q <= CYC_W'(wrap_next(int'(cyc_q), QUANTUM_CYCLES - 1));
      if (boundary) begin
        qidx_q <= QI_W'(wrap_next(int'(qidx_q), GROW_QUANTA - 1));
      end
    end
  end

  AST_CYC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cyc_q == '0)); // R1

  AST_QIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    qidx_q < QI_W'(GROW_QUANTA)); // R5

endmodule

// File: rtl/rsz_commit_tally.sv
module rsz_commit_tally #(
  parameter int COMMIT_W = 4,
  parameter int TOT_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COMMIT_W-1:0] commit_vld,
  input  logic [COMMIT_W-1:0] commit_young,
  input  logic                boundary,
  output logic [TOT_W-1:0]    quantum_total
);
  import rsz_pkg::*;

  logic [MAX_LANES-1:0] flagged_ext;
  logic [4:0]           lane_cnt;
  logic [TOT_W-1:0]     acc_q;

  always_comb begin
    flagged_ext = '0;
    flagged_ext[COMMIT_W-1:0] = commit_vld & commit_young;
  end

  assign lane_cnt      = count_lanes(flagged_ext);
  assign quantum_total = acc_q + TOT_W'(lane_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (boundary) begin
      acc_q <= '0;
    end else begin
      acc_q <= quantum_total;
    end
  end

  AST_TALLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (acc_q == '0)); // R4

  AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lane_cnt <= 5'(COMMIT_W)); // R2

endmodule

// File: rtl/rsz_decide.sv
module rsz_decide #(
  parameter int SHRINK_THRESH = 25,
  parameter int MIN_PORTIONS  = 1,
  parameter int MAX_PORTIONS  = 16,
  parameter int PORT_W        = 5,
  parameter int TOT_W         = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              grow_due,
  input  logic [TOT_W-1:0]  quantum_total,
  input  logic [PORT_W-1:0] active_portions,
  output logic              shrink_fire,
  output logic              grow_fire
);
  import rsz_pkg::*;

  logic low_rate;
  logic shrink_room;
  logic grow_room;

  assign low_rate    = rate_is_low(32'(quantum_total), SHRINK_THRESH);
  assign shrink_room = active_portions > PORT_W'(MIN_PORTIONS);
  assign grow_room   = active_portions < PORT_W'(MAX_PORTIONS);

  assign shrink_fire = boundary && low_rate && shrink_room;
  assign grow_fire   = grow_due && grow_room && !shrink_fire;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grow_fire && shrink_fire)); // R8

  AST_PULSE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (grow_fire || shrink_fire) |-> boundary); // R1

  AST_NO_SHRINK_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_fire |-> (active_portions > PORT_W'(MIN_PORTIONS))); // R7

  AST_NO_GROW_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    grow_fire |-> (active_portions < PORT_W'(MAX_PORTIONS))); // R6

  AST_GROW_ONLY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    grow_fire |-> grow_due); // R5

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (grow_fire || shrink_fire) |=> !(grow_fire || shrink_fire)); // R9

endmodule

// File: rtl/queue_resize_ctrl.sv
module queue_resize_ctrl #(
  parameter int COMMIT_W       = 4,
  parameter int QUANTUM_CYCLES = 1000,
  parameter int SHRINK_THRESH  = 25,
  parameter int GROW_QUANTA    = 5,
  parameter int MIN_PORTIONS   = 1,
  parameter int MAX_PORTIONS   = 16,
  localparam int PORT_W = $clog2(MAX_PORTIONS + 1),
  localparam int TOT_W  = $clog2(COMMIT_W * QUANTUM_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COMMIT_W-1:0] commit_vld,
  input  logic [COMMIT_W-1:0] commit_young,
  input  logic [PORT_W-1:0]   active_portions,
  output logic                grow_pulse,
  output logic                shrink_pulse
);

  logic             boundary;
  logic             grow_due;
  logic [TOT_W-1:0] quantum_total;
  logic             shrink_fire;
  logic             grow_fire;

  rsz_quantum_timer #(
    .QUANTUM_CYCLES(QUANTUM_CYCLES),
    .GROW_QUANTA   (GROW_QUANTA)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .boundary(boundary),
    .grow_due(grow_due)
  );

  rsz_commit_tally #(
    .COMMIT_W(COMMIT_W),
    .TOT_W   (TOT_W)
  ) u_tally (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_vld   (commit_vld),
    .commit_young (commit_young),
    .boundary     (boundary),
    .quantum_total(quantum_total)
  );

  rsz_decide #(
    .SHRINK_THRESH(SHRINK_THRESH),
    .MIN_PORTIONS (MIN_PORTIONS),
    .MAX_PORTIONS (MAX_PORTIONS),
    .PORT_W       (PORT_W),
    .TOT_W        (TOT_W)
  ) u_decide (
    .clk            (clk),
    .rst_n          (rst_n),
    .boundary       (boundary),
    .grow_due       (grow_due),
    .quantum_total  (quantum_total),
    .active_portions(active_portions),
    .shrink_fire    (shrink_fire),
    .grow_fire      (grow_fire)
  );

  assign grow_pulse   = grow_fire;
  assign shrink_pulse = shrink_fire;

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !(grow_pulse || shrink_pulse)); // R10

endmodule

// File: tb/tb_queue_resize_ctrl.sv
`timescale 1ns/1ps
module tb_queue_resize_ctrl;

  localparam int QCYC = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] commit_vld = '0;
  logic [3:0] commit_young = '0;
  logic [4:0] active_portions = 5'd8;
  logic       grow_pulse;
  logic       shrink_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  queue_resize_ctrl dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .commit_vld     (commit_vld),
    .commit_young   (commit_young),
    .active_portions(active_portions),
    .grow_pulse     (grow_pulse),
    .shrink_pulse   (shrink_pulse)
  );

  typedef struct packed {
    logic [11:0] tot;    // marked commits in the quantum
    logic [2:0]  per;    // marked commits per cycle at most
    logic        late;   // pack them against the boundary
    logic        noise;  // add valid-unmarked and marked-invalid lanes
    logic [4:0]  act;    // active portion count
    logic        es;     // expected shrink on the boundary
    logic        eg;     // expected grow on the boundary
  } vec_t;

  // Quantum index = table position (grow boundaries at 4, 9, 14, 19).
  localparam vec_t VECS [20] = '{
    '{12'd30,   3'd4, 1'b0, 1'b0, 5'd8,  1'b0, 1'b0}, // R3 above threshold
    '{12'd24,   3'd4, 1'b0, 1'b0, 5'd8,  1'b1, 1'b0}, // R3 one below
    '{12'd25,   3'd1, 1'b1, 1'b0, 5'd8,  1'b0, 1'b0}, // R2 last on boundary cycle, R3 exact
    '{12'd0,    3'd1, 1'b0, 1'b0, 5'd1,  1'b0, 1'b0}, // R7 floor
    '{12'd100,  3'd4, 1'b0, 1'b0, 5'd8,  1'b0, 1'b1}, // R5 grow
    '{12'd10,   3'd2, 1'b0, 1'b0, 5'd2,  1'b1, 1'b0}, // R7 just above floor
    '{12'd25,   3'd2, 1'b0, 1'b1, 5'd8,  1'b0, 1'b0}, // R2 noise ignored
    '{12'd24,   3'd2, 1'b0, 1'b1, 5'd8,  1'b1, 1'b0}, // R2 noise ignored
    '{12'd0,    3'd1, 1'b0, 1'b0, 5'd16, 1'b1, 1'b0}, // R3 at full size
    '{12'd5,    3'd1, 1'b0, 1'b0, 5'd8,  1'b1, 1'b0}, // R8 grow dropped
    '{12'd4000, 3'd4, 1'b0, 1'b0, 5'd8,  1'b0, 1'b0}, // R2 all lanes all cycles
    '{12'd26,   3'd1, 1'b1, 1'b0, 5'd4,  1'b0, 1'b0}, // R4 fresh tally
    '{12'd24,   3'd4, 1'b1, 1'b0, 5'd4,  1'b1, 1'b0}, // R4 after full quantum
    '{12'd24,   3'd4, 1'b0, 1'b0, 5'd3,  1'b1, 1'b0}, // R7 consecutive cuts
    '{12'd50,   3'd4, 1'b0, 1'b0, 5'd16, 1'b0, 1'b0}, // R6 ceiling
    '{12'd24,   3'd1, 1'b0, 1'b0, 5'd1,  1'b0, 1'b0}, // R7 floor
    '{12'd60,   3'd2, 1'b0, 1'b0, 5'd15, 1'b0, 1'b0}, // R5 not a grow quantum
    '{12'd0,    3'd1, 1'b0, 1'b0, 5'd1,  1'b0, 1'b0}, // R7 floor
    '{12'd30,   3'd3, 1'b0, 1'b0, 5'd8,  1'b0, 1'b0}, // R3
    '{12'd0,    3'd1, 1'b0, 1'b0, 5'd1,  1'b0, 1'b1}  // R8 blocked shrink keeps grow
  };

  task automatic check(input string tag, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, actual, expected, $time);
    end
  endtask

  // Called at a negedge at quantum cycle 0; returns at the negedge of the next quantum.
  task automatic run_quantum(input int tot, input int per, input bit late,
                             input bit noise, input int act,
                             input bit es, input bit eg, input int idx);
    int rem = tot;
    int start = late ? (QCYC - (tot + per - 1) / per) : 0;
    int stray = 0;
    active_portions = 5'(act);
    for (int c = 0; c < QCYC; c++) begin
      int n = 0;
      if (c >= start) n = (rem < per) ? rem : per;
      rem -= n;
      commit_vld   = '0;
      commit_young = '0;
      for (int l = 0; l < n; l++) begin
        commit_vld[l]   = 1'b1;
        commit_young[l] = 1'b1;
      end
      if (noise) begin
        commit_vld[2]   = 1'b1;  // valid, not marked
        commit_young[3] = 1'b1;  // marked, not valid
      end
      #1;
      if (c == QCYC - 1) begin
        check($sformatf("R3/R7 shrink q%0d", idx), shrink_pulse, es);
        check($sformatf("R5/R6/R8 grow q%0d", idx), grow_pulse, eg);
      end else if (grow_pulse || shrink_pulse) begin
        stray++;
      end
      @(negedge clk);
    end
    commit_vld   = '0;
    commit_young = '0;
    checks++;
    if (stray != 0) begin  // R1, R9
      errors++;
      $display("FAIL R1 q%0d stray pulses: actual=%0d expected=0", idx, stray);
    end
  endtask

  initial begin
    // R10: held in reset with heavy traffic; no pulse.
    commit_vld = 4'hF; commit_young = 4'hF; active_portions = 5'd8;
    repeat (3) @(negedge clk);
    #1;
    check("R10 grow in reset", grow_pulse, 1'b0);
    check("R10 shrink in reset", shrink_pulse, 1'b0);
    commit_vld = '0; commit_young = '0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++) begin
      run_quantum(int'(VECS[i].tot), int'(VECS[i].per), VECS[i].late, VECS[i].noise,
                  int'(VECS[i].act), VECS[i].es, VECS[i].eg, i);
    end
    run_quantum(50, 4, 1'b0, 1'b0, 8, 1'b0, 1'b0, 20);
    run_quantum(50, 4, 1'b0, 1'b0, 8, 1'b0, 1'b0, 21);

    // R10/R4: reset mid-quantum after 300 cycles of full marked traffic.
    commit_vld = 4'hF; commit_young = 4'hF;
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    active_portions = 5'd16;
    repeat (3) @(negedge clk);
    #1;
    check("R10 grow held", grow_pulse, 1'b0);
    check("R10 shrink held", shrink_pulse, 1'b0);
    commit_vld = '0; commit_young = '0;
    @(negedge clk);
    rst_n = 1'b1;
    // Tally restarted: 10 marked commits must shrink (R4, R10).
    run_quantum(10, 2, 1'b0, 1'b0, 8, 1'b1, 1'b0, 100);
    // Quantum index restarted: grow only on the fifth quantum (R5, R10).
    run_quantum(50, 4, 1'b0, 1'b0, 8, 1'b0, 1'b0, 101);
    run_quantum(50, 4, 1'b0, 1'b0, 8, 1'b0, 1'b0, 102);
    run_quantum(50, 4, 1'b0, 1'b0, 8, 1'b0, 1'b0, 103);
    run_quantum(50, 4, 1'b0, 1'b0, 8, 1'b0, 1'b1, 104);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule